// File: doc/BRIEF.md
# PHY Discovery and Link-Mode Sequencer

This block finds an Ethernet PHY on the management bus and works out the link state it negotiated. It does not drive the serial management wire itself. It issues single register reads through a simple request/acknowledge port: a PHY address and a register number go out, and 16-bit data comes back. A separate management master turns each read into wire traffic.

After a `start` pulse, the sequencer runs these steps in order:

1. It scans PHY addresses upward from 1 to 31 and stops at the first address whose status register returns a meaningful value.
2. It reads that device's identifier and places it in one of four known decode classes, or in a catch-all class.
3. It polls for link-up a bounded number of times, leaving a fixed idle gap between polls.
4. For a known class, it reads the class's vendor status register and decodes speed and duplex.

The result is a link flag, a speed code, a duplex code, and a MAC configuration word. The configuration word is the caller's base word with its speed and duplex bits rewritten.

The control is one state machine with these states:

| State | Action and transitions |
|---|---|
| IDLE | Leaves on `start` and goes to SCAN. |
| SCAN | Reads register 1 at the current address. A hit goes to IDENT. A miss at address 31 goes to DONE. Any other miss increments the address and stays in SCAN. |
| IDENT | Reads register 2. When the read completes, goes to POLL. |
| POLL | Reads register 1. Link-up goes to MODE, or to DONE for the catch-all class. Link-down on the last allowed poll goes to DONE. Any other link-down goes to GAP. |
| GAP | Waits `POLL_GAP` cycles, then returns to POLL. |
| MODE | Reads the vendor status register, then goes to DONE. |
| DONE | Raises `done` for one cycle and returns to IDLE. |

Top module: `phy_link_probe`

## Requirements
- R1: After reset:
  - `done`, `rd_req`, `no_phy` and `link_ok` are 0.
  - `speed` and `duplex` are 0, which means unknown.
  - `mac_cfg` equals `cfg_base`.
- R2: The scan reads register 1 at addresses 1, 2, 3 and upward, one at a time. It stops at the first address whose data is neither 16'hFFFF nor 16'h0000. Address 0 is never requested.
- R3: If no address from 1 to 31 responds:
  - `no_phy` is set and `link_ok` stays 0.
  - `speed` and `duplex` stay 0.
  - No further reads follow the scan.
  - `done` pulses.
- R4: After a hit, the block reads register 2 once at the found address and classifies the device by exact match:
  - 16'h0016 is class A.
  - 16'h0022 is class B.
  - 16'h0141 is class C.
  - 16'h0013 is class D.
  - Any other value is the catch-all class.
- R5: Link polling works as follows:
  - Each poll reads register 1, and link is up when bit 2 is 1.
  - There are at most `POLL_LIMIT` polls, with more than `POLL_GAP` cycles between successive polls.
  - If all polls fail, `link_ok`, `speed` and `duplex` end at 0.
- R6: Class A reads register 18. Bit 7 set means 100 Mb/s and clear means 10 Mb/s. Bit 6 set means full duplex.
- R7: Class B reads register 18. Bit 10 set means 100 Mb/s and clear means 10 Mb/s. Bit 11 set means full duplex.
- R8: Class C reads register 17. Bits 15:14 equal to 2'b10 mean 1000 Mb/s, 2'b01 mean 100 Mb/s, and any other value means 10 Mb/s. Bit 13 set means full duplex.
- R9: Class D reads register 17. Bits 15:14 equal to 2'b11 mean 1000 Mb/s, 2'b10 mean 100 Mb/s, and any other value means 10 Mb/s. Bit 9 set means full duplex.
- R10: For the catch-all class with link up:
  - `link_ok` is 1 and no vendor register is read.
  - `speed` and `duplex` stay 0.
  - `mac_cfg` equals `cfg_base`.
- R11: Output encoding and the configuration word:
  - `speed` is 1 for 10M, 2 for 100M and 3 for 1000M.
  - `duplex` is 1 for half and 2 for full.
  - When `speed` is nonzero, `mac_cfg` is `cfg_base` with bits 16, 19 and 20 replaced: bit 19 set for 10M, bit 16 set for 1000M, bit 20 set for full duplex.
  - All other bits of `mac_cfg` always follow `cfg_base`.
- R12: `done` is high for exactly one cycle per run. The results hold until the next `start`, and `start` clears them.
- R13: While `rd_req` is high and `rd_ack` is low, `rd_req`, `rd_phy_addr` and `rd_reg_addr` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a discovery run (taken in IDLE) |
| cfg_base | input | CFG_W | MAC configuration word to be rewritten |
| rd_req | output | 1 | Read request to the management master |
| rd_phy_addr | output | 5 | PHY address of the read |
| rd_reg_addr | output | 5 | Register number of the read |
| rd_ack | input | 1 | Read complete; rd_data valid this cycle |
| rd_data | input | 16 | Returned register value |
| done | output | 1 | One-cycle end-of-run pulse |
| no_phy | output | 1 | No device answered the scan |
| link_ok | output | 1 | Link detected up |
| speed | output | 2 | Speed code: 0 unknown, 1 10M, 2 100M, 3 1000M |
| duplex | output | 2 | Duplex code: 0 unknown, 1 half, 2 full |
| mac_cfg | output | CFG_W | cfg_base with the speed and duplex bits rewritten |

## Verification
Random runs vary several inputs at once:
- the PHY's address, including no PHY at all;
- the identifier, drawn from the four known values or a random one;
- the number of failed polls before link-up, including never;
- the contents of registers 17 and 18;
- the base configuration word.

A bench-side PHY model answers reads with a variable latency. It flags any read that breaks the expected order of addresses and registers, and it measures the spacing between polls. Because registers 17 and 18 carry unrelated random values, a read of the wrong vendor register or a bit-field decode belonging to another class gives a different speed or duplex. Directed runs cover the corners: a PHY at address 1 and at address 31, an empty bus, link-up on the final poll, link never up, each class at each of its speed encodings, and an unknown identifier.

// File: rtl/phy_probe_pkg.sv
package phy_probe_pkg;

    localparam int PHY_AW = 5;
    localparam int MD_W   = 16;

    localparam logic [PHY_AW-1:0] ADDR_FIRST = 5'd1;
    localparam logic [PHY_AW-1:0] ADDR_LAST  = 5'd31;

    localparam logic [4:0] RG_STAT  = 5'd1;
    localparam logic [4:0] RG_IDENT = 5'd2;
    localparam logic [4:0] RG_VS17  = 5'd17;
    localparam logic [4:0] RG_VS18  = 5'd18;

    localparam int LINK_BIT  = 2;
    localparam int N_CLASSES = 4;

    localparam int CFG_B1000 = 16;
    localparam int CFG_B10   = 19;
    localparam int CFG_BFDX  = 20;

    typedef enum logic [2:0] {
        CLS_NONE, CLS_A, CLS_B, CLS_C, CLS_D, CLS_OTHER
    } phy_class_e;

    typedef enum logic [1:0] {
        SPD_UNK, SPD_10, SPD_100, SPD_1000
    } speed_e;

    typedef enum logic [1:0] {
        DPX_UNK, DPX_HALF, DPX_FULL, DPX_RSV
    } duplex_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SCAN, ST_IDENT, ST_POLL, ST_GAP, ST_MODE, ST_DONE
    } probe_state_e;

endpackage

// File: rtl/phy_class_match.sv
module phy_class_match
    import phy_probe_pkg::*;
#(
    parameter logic [N_CLASSES*MD_W-1:0] CLASS_IDS = {16'h0013, 16'h0141, 16'h0022, 16'h0016}
) (
    input  logic [MD_W-1:0] id_word,
    output phy_class_e      cls
);

    logic [N_CLASSES-1:0] hit;

    for (genvar g = 0; g < N_CLASSES; g++) begin : g_cmp
        assign hit[g] = (id_word == CLASS_IDS[g*MD_W +: MD_W]);
    end

    always_comb begin
        cls = CLS_OTHER;
        for (int k = N_CLASSES - 1; k >= 0; k--) begin
            if (hit[k]) begin
                cls = phy_class_e'(k + 1);
            end
        end
    end

endmodule

// File: rtl/phy_mode_decode.sv
module phy_mode_decode
    import phy_probe_pkg::*;
(
    input  phy_class_e      cls,
    input  logic [MD_W-1:0] vs_data,
    output logic [4:0]      vs_reg,
    output speed_e          spd,
    output duplex_e         dpx
);

    always_comb begin
        vs_reg = RG_VS17;
        spd    = SPD_UNK;
        dpx    = DPX_UNK;
        unique case (cls)
            CLS_A: begin
                vs_reg = RG_VS18;
                spd    = vs_data[7] ? SPD_100 : SPD_10;
                dpx    = vs_data[6] ? DPX_FULL : DPX_HALF;
            end
            CLS_B: begin
                vs_reg = RG_VS18;
                spd    = vs_data[10] ? SPD_100 : SPD_10;
                dpx    = vs_data[11] ? DPX_FULL : DPX_HALF;
            end
            CLS_C: begin
                vs_reg = RG_VS17;
                unique case (vs_data[15:14])
                    2'b10:   spd = SPD_1000;
                    2'b01:   spd = SPD_100;
                    default: spd = SPD_10;
                endcase
                dpx = vs_data[13] ? DPX_FULL : DPX_HALF;
            end
            CLS_D: begin
                vs_reg = RG_VS17;
                unique case (vs_data[15:14])
                    2'b11:   spd = SPD_1000;
                    2'b10:   spd = SPD_100;
                    default: spd = SPD_10;
                endcase
                dpx = vs_data[9] ? DPX_FULL : DPX_HALF;
            end
            default: begin
                vs_reg = RG_VS17;
            end
        endcase
    end

endmodule

// File: rtl/phy_cfg_merge.sv
module phy_cfg_merge
    import phy_probe_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic [CFG_W-1:0] base,
    input  speed_e           spd,
    input  duplex_e          dpx,
    output logic [CFG_W-1:0] merged
);

    localparam logic [CFG_W-1:0] FIELD_MASK =
        (CFG_W'(1) << CFG_B1000) | (CFG_W'(1) << CFG_B10) | (CFG_W'(1) << CFG_BFDX);

    logic [CFG_W-1:0] field;

    always_comb begin
        field = '0;
        field[CFG_B10]   = (spd == SPD_10);
        field[CFG_B1000] = (spd == SPD_1000);
        field[CFG_BFDX]  = (dpx == DPX_FULL);
        if (spd == SPD_UNK) begin
            merged = base;
        end else begin
            merged = (base & ~FIELD_MASK) | field;
        end
    end

endmodule

// File: rtl/phy_link_probe.sv
module phy_link_probe
    import phy_probe_pkg::*;
#(
    parameter int          POLL_LIMIT = 4096,
    parameter int          POLL_GAP   = 1000,
    parameter int          CFG_W      = 32,
    parameter logic [15:0] ID_A       = 16'h0016,
    parameter logic [15:0] ID_B       = 16'h0022,
    parameter logic [15:0] ID_C       = 16'h0141,
    parameter logic [15:0] ID_D       = 16'h0013
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CFG_W-1:0]  cfg_base,
    output logic              rd_req,
    output logic [4:0]        rd_phy_addr,
    output logic [4:0]        rd_reg_addr,
    input  logic              rd_ack,
    input  logic [15:0]       rd_data,
    output logic              done,
    output logic              no_phy,
    output logic              link_ok,
    output logic [1:0]        speed,
    output logic [1:0]        duplex,
    output logic [CFG_W-1:0]  mac_cfg
);

    localparam int PCNT_W = $clog2(POLL_LIMIT + 1);
    localparam int GCNT_W = $clog2(POLL_GAP + 1);
    localparam logic [PCNT_W-1:0] POLL_END = PCNT_W'(POLL_LIMIT - 1);
    localparam logic [GCNT_W-1:0] GAP_END  = GCNT_W'(POLL_GAP - 1);

    probe_state_e      state, state_nxt;
    logic [PHY_AW-1:0] scan_addr;
    logic [PCNT_W-1:0] poll_cnt;
    logic [GCNT_W-1:0] gap_cnt;
    phy_class_e        cls_q, cls_match;
    speed_e            spd_q, dec_spd;
    duplex_e           dpx_q, dec_dpx;
    logic [4:0]        vs_reg;
    logic              responder, last_addr, link_up, last_poll;

    phy_class_match #(
        .CLASS_IDS({ID_D, ID_C, ID_B, ID_A})
    ) u_match (
        .id_word (rd_data),
        .cls     (cls_match)
    );

    phy_mode_decode u_decode (
        .cls     (cls_q),
        .vs_data (rd_data),
        .vs_reg  (vs_reg),
        .spd     (dec_spd),
        .dpx     (dec_dpx)
    );

    phy_cfg_merge #(
        .CFG_W (CFG_W)
    ) u_merge (
        .base   (cfg_base),
        .spd    (spd_q),
        .dpx    (dpx_q),
        .merged (mac_cfg)
    );

    assign responder = (rd_data != 16'hFFFF) && (rd_data != 16'h0000);
    assign last_addr = (scan_addr == ADDR_LAST);
    assign link_up   = rd_data[LINK_BIT];
    assign last_poll = (poll_cnt == POLL_END);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start) state_nxt = ST_SCAN;
            ST_SCAN:  if (rd_ack) begin
                          if (responder)      state_nxt = ST_IDENT;
                          else if (last_addr) state_nxt = ST_DONE;
                      end
            ST_IDENT: if (rd_ack) state_nxt = ST_POLL;
            ST_POLL:  if (rd_ack) begin
                          if (link_up)        state_nxt = (cls_q == CLS_OTHER) ? ST_DONE : ST_MODE;
                          else if (last_poll) state_nxt = ST_DONE;
                          else                state_nxt = ST_GAP;
                      end
            ST_GAP:   if (gap_cnt == GAP_END) state_nxt = ST_POLL;
            ST_MODE:  if (rd_ack) state_nxt = ST_DONE;
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_addr <= ADDR_FIRST;
            poll_cnt  <= '0;
            gap_cnt   <= '0;
            cls_q     <= CLS_NONE;
            spd_q     <= SPD_UNK;
            dpx_q     <= DPX_UNK;
            no_phy    <= 1'b0;
            link_ok   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    scan_addr <= ADDR_FIRST;
                    poll_cnt  <= '0;
                    gap_cnt   <= '0;
                    cls_q     <= CLS_NONE;
                    spd_q     <= SPD_UNK;
                    dpx_q     <= DPX_UNK;
                    no_phy    <= 1'b0;
                    link_ok   <= 1'b0;
                end
                ST_SCAN: if (rd_ack && !responder) begin
                    if (last_addr) no_phy    <= 1'b1;
                    else           scan_addr <= scan_addr + 1'b1;
                end
                ST_IDENT: if (rd_ack) cls_q <= cls_match;
                ST_POLL: if (rd_ack) begin
                    poll_cnt <= poll_cnt + 1'b1;
                    gap_cnt  <= '0;
                    if (link_up) link_ok <= 1'b1;
                end
                ST_GAP:  gap_cnt <= gap_cnt + 1'b1;
                ST_MODE: if (rd_ack) begin
                    spd_q <= dec_spd;
                    dpx_q <= dec_dpx;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_req      = 1'b0;
        rd_reg_addr = RG_STAT;
        done        = 1'b0;
        unique case (state)
            ST_SCAN:  rd_req = 1'b1;
            ST_IDENT: begin rd_req = 1'b1; rd_reg_addr = RG_IDENT; end
            ST_POLL:  rd_req = 1'b1;
            ST_MODE:  begin rd_req = 1'b1; rd_reg_addr = vs_reg; end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign rd_phy_addr = scan_addr;
    assign speed       = spd_q;
    assign duplex      = dpx_q;

endmodule

// File: rtl/phy_link_probe_chk.sv
module phy_link_probe_chk #(
    parameter int CFG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CFG_W-1:0] cfg_base,
    input logic             rd_req,
    input logic [4:0]       rd_phy_addr,
    input logic [4:0]       rd_reg_addr,
    input logic             rd_ack,
    input logic             done,
    input logic             no_phy,
    input logic             link_ok,
    input logic [1:0]       speed,
    input logic [1:0]       duplex,
    input logic [CFG_W-1:0] mac_cfg
);

    localparam logic [CFG_W-1:0] KEEP_MASK =
        ~((CFG_W'(1) << 16) | (CFG_W'(1) << 19) | (CFG_W'(1) << 20));

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_phy_addr) && $stable(rd_reg_addr)));

    // R2
    addr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_phy_addr != 5'd0));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ack && !start) |=> $stable({no_phy, link_ok, speed, duplex}));

    // R3
    no_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_phy |-> (!link_ok && speed == 2'd0 && duplex == 2'd0));

    // R5
    speed_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed != 2'd0) |-> (link_ok && duplex != 2'd0));

    // R11
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mac_cfg & KEEP_MASK) == (cfg_base & KEEP_MASK)));

    // R11
    cfg_gig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed == 2'd3) |-> (mac_cfg[16] && !mac_cfg[19]));

endmodule

bind phy_link_probe phy_link_probe_chk #(.CFG_W(CFG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cfg_base    (cfg_base),
    .rd_req      (rd_req),
    .rd_phy_addr (rd_phy_addr),
    .rd_reg_addr (rd_reg_addr),
    .rd_ack      (rd_ack),
    .done        (done),
    .no_phy      (no_phy),
    .link_ok     (link_ok),
    .speed       (speed),
    .duplex      (duplex),
    .mac_cfg     (mac_cfg)
);

// File: tb/test_phy_link_probe.sv
module test_phy_link_probe;

    localparam int LIMIT = 8;
    localparam int GAP   = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] cfg_base;
    logic        rd_req;
    logic [4:0]  rd_phy_addr;
    logic [4:0]  rd_reg_addr;
    logic        rd_ack;
    logic [15:0] rd_data;
    logic        done;
    logic        no_phy;
    logic        link_ok;
    logic [1:0]  speed;
    logic [1:0]  duplex;
    logic [31:0] mac_cfg;

    // 8 ns period (125 MHz)
    always #4 clk = ~clk;

    phy_link_probe #(
        .POLL_LIMIT (LIMIT),
        .POLL_GAP   (GAP)
    ) i_phy_link_probe (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_base    (cfg_base),
        .rd_req      (rd_req),
        .rd_phy_addr (rd_phy_addr),
        .rd_reg_addr (rd_reg_addr),
        .rd_ack      (rd_ack),
        .rd_data     (rd_data),
        .done        (done),
        .no_phy      (no_phy),
        .link_ok     (link_ok),
        .speed       (speed),
        .duplex      (duplex),
        .mac_cfg     (mac_cfg)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // PHY model configuration and trackers
    int          m_phy;
    logic [15:0] m_id, m_v17, m_v18;
    int          m_after;
    int          exp_scan;
    bit          id_seen;
    int          polls;
    int          mode_reads;
    int          mode_reg;
    int          last_poll_cyc;
    bit          seq_bad;
    bit          gap_bad;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic serve();
        int a, r;
        a = rd_phy_addr;
        r = rd_reg_addr;
        if (!id_seen) begin
            if (r == 1 && a == exp_scan) begin
                exp_scan++;
                if (a == m_phy) rd_data = 16'h7849;
                else            rd_data = ($urandom_range(0, 1) != 0) ? 16'hFFFF : 16'h0000;
            end else if (r == 2 && m_phy != 0 && a == m_phy && exp_scan == m_phy + 1) begin
                id_seen = 1;
                rd_data = m_id;
            end else begin
                seq_bad = 1;
                rd_data = 16'hFFFF;
            end
        end else if (a != m_phy) begin
            seq_bad = 1;
            rd_data = 16'h0000;
        end else begin
            case (r)
                1: begin
                    if (mode_reads != 0) seq_bad = 1;
                    if (polls > 0 && (cyc - last_poll_cyc) <= GAP) gap_bad = 1;
                    last_poll_cyc = cyc;
                    rd_data = 16'h7849 | ((polls >= m_after) ? 16'h0004 : 16'h0000);
                    polls++;
                end
                17: begin mode_reads++; mode_reg = 17; rd_data = m_v17; end
                18: begin mode_reads++; mode_reg = 18; rd_data = m_v18; end
                default: begin seq_bad = 1; rd_data = 16'h0000; end
            endcase
        end
    endtask

    // Management responder with 0..2 cycles of latency
    initial begin
        rd_ack  = 1'b0;
        rd_data = 16'h0000;
        forever begin
            @(negedge clk);
            if (rd_req) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                serve();
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
            end
        end
    end

    // Expected decode computed from R4, R6..R9
    task automatic expect_mode(input logic [15:0] id, input logic [15:0] v17, input logic [15:0] v18,
                               output int spd, output int dpx, output int reg_n);
        spd = 0; dpx = 0; reg_n = 0;
        case (id)
            16'h0016: begin reg_n = 18; spd = v18[7] ? 2 : 1;  dpx = v18[6] ? 2 : 1;  end
            16'h0022: begin reg_n = 18; spd = v18[10] ? 2 : 1; dpx = v18[11] ? 2 : 1; end
            16'h0141: begin
                reg_n = 17;
                spd = (v17[15:14] == 2'b10) ? 3 : (v17[15:14] == 2'b01) ? 2 : 1;
                dpx = v17[13] ? 2 : 1;
            end
            16'h0013: begin
                reg_n = 17;
                spd = (v17[15:14] == 2'b11) ? 3 : (v17[15:14] == 2'b10) ? 2 : 1;
                dpx = v17[9] ? 2 : 1;
            end
            default: ;
        endcase
    endtask

    function automatic logic [31:0] expect_cfg(input logic [31:0] base, input int spd, input int dpx);
        logic [31:0] v;
        v = base;
        if (spd != 0) begin
            v[19] = (spd == 1);
            v[16] = (spd == 3);
            v[20] = (dpx == 2);
        end
        return v;
    endfunction

    task automatic run_case(input int phy, input logic [15:0] id, input logic [15:0] v17,
                            input logic [15:0] v18, input int after, input logic [31:0] base);
        int  spd_e, dpx_e, reg_e, polls_e, wait_n;
        bit  up, seen;
        string rq;
        m_phy = phy; m_id = id; m_v17 = v17; m_v18 = v18; m_after = after;
        exp_scan = 1; id_seen = 0; polls = 0; mode_reads = 0; mode_reg = 0;
        seq_bad = 0; gap_bad = 0; last_poll_cyc = 0;
        cfg_base = base;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        seen = 0;
        wait_n = 0;
        while (!seen && wait_n < 3000) begin
            if (done) seen = 1;
            else begin @(negedge clk); wait_n++; end
        end
        chk(seen, "R12", "done seen", 32'(seen), 32'd1);
        if (!seen) return;

        up = (phy != 0) && (after < LIMIT);
        spd_e = 0; dpx_e = 0; reg_e = 0;
        if (up) expect_mode(id, v17, v18, spd_e, dpx_e, reg_e);
        polls_e = (phy == 0) ? 0 : (up ? after + 1 : LIMIT);
        rq = (phy == 0) ? "R3" : (!up ? "R5" : (reg_e == 0 ? "R10" : "R11"));

        chk(no_phy == (phy == 0), "R3", "no_phy", 32'(no_phy), 32'(phy == 0));
        chk(link_ok == up, "R5", "link_ok", 32'(link_ok), 32'(up));
        chk(speed == 2'(spd_e), rq, "speed", 32'(speed), 32'(spd_e));
        chk(duplex == 2'(dpx_e), rq, "duplex", 32'(duplex), 32'(dpx_e));
        chk(mac_cfg == expect_cfg(base, spd_e, dpx_e), "R11", "mac_cfg", mac_cfg, expect_cfg(base, spd_e, dpx_e));
        chk(!seq_bad, "R2", "read order", 32'(seq_bad), 32'd0);
        chk(exp_scan == ((phy == 0) ? 32 : phy + 1), "R2", "scan reads", 32'(exp_scan - 1),
            32'((phy == 0) ? 31 : phy));
        chk(id_seen == (phy != 0), "R4", "id read", 32'(id_seen), 32'(phy != 0));
        chk(polls == polls_e, "R5", "poll count", 32'(polls), 32'(polls_e));
        chk(!gap_bad, "R5", "poll gap", 32'(gap_bad), 32'd0);
        chk(mode_reads == (reg_e != 0 ? 1 : 0), "R10", "vendor reads", 32'(mode_reads), 32'(reg_e != 0));
        chk(mode_reg == reg_e, "R4", "vendor reg", 32'(mode_reg), 32'(reg_e));
        @(negedge clk);
        chk(!done, "R12", "done width", 32'(done), 32'd0);
        chk(link_ok == up && speed == 2'(spd_e), "R12", "result hold", 32'({link_ok, speed}), 32'({up, 2'(spd_e)}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] ids [5];
        void'($urandom(32'h0C0FFEE5));
        rst_n = 1'b0;
        start = 1'b0;
        cfg_base = 32'hA5F3_0C3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!done && !rd_req && !no_phy && !link_ok, "R1", "flags", 32'({done, rd_req, no_phy, link_ok}), 32'd0);
        chk(speed == 2'd0 && duplex == 2'd0, "R1", "speed/duplex", 32'({speed, duplex}), 32'd0);
        chk(mac_cfg == cfg_base, "R1", "mac_cfg", mac_cfg, cfg_base);

        // Directed corners
        run_case(0,  16'h0016, 16'h0000, 16'h00C0, 0, 32'hFFFF_FFFF);         // R3 empty bus
        run_case(31, 16'h0016, 16'h0000, 16'h00C0, 0, 32'h0000_0000);         // R6 100 full
        run_case(1,  16'h0016, 16'hFFFF, 16'h0040, 2, 32'h0018_0000);         // R6 10 full
        run_case(5,  16'h0022, 16'h0000, 16'h0C00, 0, 32'h0000_0000);         // R7 100 full
        run_case(6,  16'h0022, 16'hFFFF, 16'h03FF, 1, 32'h0011_0000);         // R7 10 half
        run_case(1,  16'h0141, 16'hA000, 16'hFFFF, 0, 32'h0000_0000);         // R8 1000 full
        run_case(2,  16'h0141, 16'h4000, 16'h0000, 0, 32'h0001_0000);         // R8 100 half
        run_case(3,  16'h0141, 16'hC000, 16'h0000, 0, 32'h0000_0000);         // R8 10 half
        run_case(4,  16'h0013, 16'hC200, 16'h0000, 0, 32'h0000_0000);         // R9 1000 full
        run_case(4,  16'h0013, 16'h8000, 16'h0000, 0, 32'h0010_0000);         // R9 100 half
        run_case(4,  16'h0013, 16'h4200, 16'h0000, 0, 32'h0000_0000);         // R9 10 full
        run_case(9,  16'h0302, 16'hA000, 16'h00C0, 0, 32'h1234_5678);         // R10 other
        run_case(7,  16'h0141, 16'hA000, 16'h0000, LIMIT - 1, 32'h0);         // R5 last poll
        run_case(7,  16'h0141, 16'hA000, 16'h0000, LIMIT, 32'hDEAD_BEEF);     // R5 never

        // Random runs
        ids[0] = 16'h0016; ids[1] = 16'h0022; ids[2] = 16'h0141; ids[3] = 16'h0013;
        for (int n = 0; n < 40; n++) begin
            int          phy, sel;
            logic [15:0] id;
            ids[4] = 16'($urandom());
            sel = $urandom_range(0, 4);
            id  = ids[sel];
            phy = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 31);
            run_case(phy, id, 16'($urandom()), 16'($urandom()), $urandom_range(0, LIMIT), $urandom());
        end
        finish_run();
    end

endmodule